// File: doc/BRIEF.md
# Floppy Controller Host Phase Sequencer

This block is the host side of a floppy disk controller. It owns the main status byte, the digital output byte and the data-rate byte, and it steps the controller through three phases: command, execution and result. The phase is held only in the status bits: request-for-master, direction, non-DMA and command-busy. Which of these bits are set decides whether a host access to the data port is accepted.

A downstream command engine watches the command bytes and starts an execution phase with a length, a DMA or programmed-I/O choice and a direction. A DMA execution blocks the data port and raises a DMA request. Each acknowledge counts one byte. A programmed-I/O execution moves the bytes through the data port instead. When the count reaches the length, the block loads a seven-byte result from the engine. The host reads those bytes out in order, and the block then returns to the command phase. A power-down request in the rate byte resets the controller, and so does a release of the active-low reset bit in the output byte.

Host register select codes: 0 is the output byte (read and write). 1 is the status byte on read and the rate byte on write. 2 is the data port. 3 reads the rate byte back.

Top module: `fdc_host_seq`

## Requirements
- R1: After reset the status byte reads 0x80, the output byte reads 0x04, the rate byte reads 0x00, and irq, dma_req and all three flags are low. Status bits: bit 7 request-for-master, bit 6 direction (1 = controller to host), bit 5 non-DMA, bit 4 command-busy, bits 3..0 zero.
- R2: A data-port read is accepted only when status bits 7 and 6 are both set. Otherwise it returns 0x00 and leaves the status byte unchanged.
- R3: A data-port write is accepted only when status bit 7 is set and bit 6 is clear. Otherwise it produces no strobe and leaves the status byte unchanged.
- R4: Starting a DMA execution sets command-busy, clears request-for-master (status 0x10) and raises dma_req.
- R5: Starting a programmed-I/O execution sets command-busy and non-DMA, sets direction only for a controller-to-host transfer (status 0xB0 or 0xF0), and raises irq.
- R6: In programmed-I/O write mode, the write that brings the byte count to the length ends the transfer.
- R7: Ending a transfer drops dma_req, clears non-DMA, loads the result bytes and raises irq, with status 0xD0. A DMA transfer ends on the acknowledge that reaches the length.
- R8: Result bytes are read from the data port in index order (byte i = res_bytes[8i+7:8i]). After the seventh read the status byte returns to 0x80.
- R9: The first command byte sets flag_multi from bit 7, flag_format when bits 4..0 equal 0x0D, and flag_seek when bits 4..0 equal 0x0F. Later bytes leave the flags unchanged.
- R10: Writing the rate byte with bit 6 (power-down) set resets the controller with irq raised, and the written value is stored.
- R11: Reading the status byte clears rate bit 6 and sets output bit 2.
- R12: While output bit 2 (active-low reset) is 0, data writes are ignored. Writing bit 2 from 0 to 1 resets the controller with irq raised and clears rate bit 6.
- R13: Any accepted data-port access clears irq.
- R14: In programmed-I/O read mode, data-port reads return media_rd_data, and the read that reaches the length ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_sel | input | 2 | Host register select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| exec_start | input | 1 | Start an execution phase |
| exec_dma | input | 1 | 1 = DMA execution |
| exec_to_host | input | 1 | 1 = controller-to-host transfer |
| exec_len | input | LEN_W | Transfer length in bytes |
| res_bytes | input | 8*RES_LEN | Result bytes to load at transfer end |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one per byte |
| media_rd_data | input | 8 | Byte offered for programmed-I/O reads |
| media_rd_take | output | 1 | Programmed-I/O read byte consumed |
| media_wr_strobe | output | 1 | Programmed-I/O write byte valid |
| media_wr_data | output | 8 | Programmed-I/O write byte |
| cmd_valid | output | 1 | Command byte accepted |
| cmd_byte | output | 8 | Accepted command byte |
| flag_multi | output | 1 | Multi-track flag |
| flag_format | output | 1 | Format flag |
| flag_seek | output | 1 | Seek flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties take for granted that host_rd and host_wr are never high together. They also expect exec_start only in the command phase, with a length of at least one, and never in the same cycle as a data-port access, and dma_ack only while dma_req is high. The stimulus keeps within these limits by construction. Each vector drives exactly one operation for one cycle, execution starts are issued only after the command bytes, and acknowledges are given only after dma_req has been seen high.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
    localparam int MSR_RQM = 7;
    localparam int MSR_DIO = 6;
    localparam int MSR_NDMA = 5;
    localparam int MSR_CB = 4;
    localparam int DOR_NRST = 2;
    localparam int DSR_PD = 6;
    localparam logic [7:0] DOR_INIT = 8'h04;
    localparam logic [4:0] OPC_FORMAT = 5'h0D;
    localparam logic [4:0] OPC_SEEK = 5'h0F;

    typedef enum logic [1:0] {
        SEL_DOR  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_RATE = 2'd3
    } host_sel_e;
endpackage

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs
    import fdc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_dor_i,
    input  logic       wr_rate_i,
    input  logic       rd_status_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] dor_o,
    output logic [7:0] dsr_o,
    output logic       ctl_reset_o
);
    typedef struct packed {
        logic [7:0] dor;
        logic [7:0] dsr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        ctl_reset_o = 1'b0;
        if (wr_dor_i) begin
            r_d.dor = wdata_i;
            // release of the active-low reset bit restarts the controller
            if (!r_q.dor[DOR_NRST] && wdata_i[DOR_NRST]) begin
                ctl_reset_o = 1'b1;
                r_d.dsr[DSR_PD] = 1'b0;
            end
        end
        if (wr_rate_i) begin
            if (wdata_i[DSR_PD]) begin
                ctl_reset_o = 1'b1;
                r_d.dor[DOR_NRST] = 1'b1;
            end
            r_d.dsr = wdata_i;
        end
        if (rd_status_i) begin
            r_d.dsr[DSR_PD] = 1'b0;
            r_d.dor[DOR_NRST] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.dor <= DOR_INIT;
            r_q.dsr <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign dor_o = r_q.dor;
    assign dsr_o = r_q.dsr;
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
    parameter int RES_LEN = 7,
    parameter int IDX_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [8*RES_LEN-1:0] bytes_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [7:0]           byte_o
);
    logic [7:0] buf_d [RES_LEN];
    logic [7:0] buf_q [RES_LEN];

    for (genvar i = 0; i < RES_LEN; i++) begin : g_slot
        assign buf_d[i] = load_i ? bytes_i[8*i +: 8] : buf_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q[i] <= 8'h00;
            end else begin
                buf_q[i] <= buf_d[i];
            end
        end
    end

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < RES_LEN; i++) begin
            if (idx_i == IDX_W'(i)) begin
                byte_o = buf_q[i];
            end
        end
    end
endmodule

// File: rtl/fdc_phase.sv
module fdc_phase
    import fdc_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int RES_LEN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_reset_i,
    input  logic             data_wr_i,
    input  logic             data_rd_i,
    input  logic [7:0]       wdata_i,
    input  logic             exec_start_i,
    input  logic             exec_dma_i,
    input  logic             exec_to_host_i,
    input  logic [LEN_W-1:0] exec_len_i,
    input  logic             dma_ack_i,
    output logic [7:0]       msr_o,
    output logic [LEN_W-1:0] pos_o,
    output logic             dma_req_o,
    output logic             irq_o,
    output logic             multi_o,
    output logic             format_o,
    output logic             seek_o,
    output logic             res_load_o,
    output logic             cmd_valid_o,
    output logic             media_wr_o,
    output logic             media_take_o
);
    typedef struct packed {
        logic             rqm;
        logic             dio;
        logic             ndma;
        logic             cb;
        logic [LEN_W-1:0] pos;
        logic [LEN_W-1:0] len;
        logic             dma_req;
        logic             irq;
        logic             multi;
        logic             format;
        logic             seek;
    } ph_t;

    localparam int PH_W = $bits(ph_t);
    localparam ph_t PH_IDLE = ph_t'({1'b1, {(PH_W-1){1'b0}}});
    localparam logic [LEN_W-1:0] RES_CNT = LEN_W'(RES_LEN);

    ph_t s_d, s_q;
    logic [LEN_W-1:0] pos_inc;
    logic end_xfer;

    assign pos_inc = s_q.pos + 1'b1;

    always_comb begin
        s_d = s_q;
        end_xfer = 1'b0;
        res_load_o = 1'b0;
        cmd_valid_o = 1'b0;
        media_wr_o = 1'b0;
        media_take_o = 1'b0;
        if (ctl_reset_i) begin
            s_d = PH_IDLE;
            s_d.irq = 1'b1;
        end else begin
            if (data_wr_i) begin
                s_d.irq = 1'b0;
                s_d.pos = pos_inc;
                if (s_q.ndma) begin
                    media_wr_o = 1'b1;
                    end_xfer = (pos_inc == s_q.len);
                end else begin
                    cmd_valid_o = 1'b1;
                    if (s_q.pos == '0) begin
                        s_d.multi = wdata_i[7];
                        s_d.format = (wdata_i[4:0] == OPC_FORMAT);
                        s_d.seek = (wdata_i[4:0] == OPC_SEEK);
                    end
                end
            end
            if (data_rd_i) begin
                s_d.irq = 1'b0;
                s_d.pos = pos_inc;
                if (s_q.ndma) begin
                    media_take_o = 1'b1;
                    end_xfer = (pos_inc == s_q.len);
                end else if (pos_inc == s_q.len) begin
                    // last result byte: back to the command phase
                    s_d.cb = 1'b0;
                    s_d.dio = 1'b0;
                    s_d.pos = '0;
                end
            end
            if (exec_start_i && !s_q.cb) begin
                s_d.cb = 1'b1;
                s_d.pos = '0;
                s_d.len = exec_len_i;
                if (exec_dma_i) begin
                    s_d.rqm = 1'b0;
                    s_d.dma_req = 1'b1;
                end else begin
                    s_d.ndma = 1'b1;
                    s_d.dio = exec_to_host_i;
                    s_d.irq = 1'b1;
                end
            end
            if (dma_ack_i && s_q.dma_req) begin
                s_d.pos = pos_inc;
                end_xfer = (pos_inc == s_q.len);
            end
            if (end_xfer) begin
                s_d.dma_req = 1'b0;
                s_d.ndma = 1'b0;
                s_d.rqm = 1'b1;
                s_d.dio = 1'b1;
                s_d.cb = 1'b1;
                s_d.len = RES_CNT;
                s_d.pos = '0;
                s_d.irq = 1'b1;
                res_load_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign msr_o = {s_q.rqm, s_q.dio, s_q.ndma, s_q.cb, 4'b0000};
    assign pos_o = s_q.pos;
    assign dma_req_o = s_q.dma_req;
    assign irq_o = s_q.irq;
    assign multi_o = s_q.multi;
    assign format_o = s_q.format;
    assign seek_o = s_q.seek;
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
    import fdc_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int RES_LEN = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           host_sel,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    input  logic                 exec_start,
    input  logic                 exec_dma,
    input  logic                 exec_to_host,
    input  logic [LEN_W-1:0]     exec_len,
    input  logic [8*RES_LEN-1:0] res_bytes,
    output logic                 dma_req,
    input  logic                 dma_ack,
    input  logic [7:0]           media_rd_data,
    output logic                 media_rd_take,
    output logic                 media_wr_strobe,
    output logic [7:0]           media_wr_data,
    output logic                 cmd_valid,
    output logic [7:0]           cmd_byte,
    output logic                 flag_multi,
    output logic                 flag_format,
    output logic                 flag_seek,
    output logic                 irq
);
    logic [7:0] dor_w, dsr_w, msr_w, res_byte_w;
    logic [LEN_W-1:0] pos_w;
    logic ctl_reset_w, res_load_w;
    logic wr_dor, wr_rate, rd_status, rd_ok, wr_ok;

    assign wr_dor = host_wr && (host_sel == SEL_DOR);
    assign wr_rate = host_wr && (host_sel == SEL_STAT);
    assign rd_status = host_rd && (host_sel == SEL_STAT);
    assign rd_ok = host_rd && (host_sel == SEL_DATA) && msr_w[MSR_RQM] && msr_w[MSR_DIO];
    assign wr_ok = host_wr && (host_sel == SEL_DATA) && msr_w[MSR_RQM] && !msr_w[MSR_DIO]
                   && dor_w[DOR_NRST];

    fdc_ctl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_dor_i    (wr_dor),
        .wr_rate_i   (wr_rate),
        .rd_status_i (rd_status),
        .wdata_i     (host_wdata),
        .dor_o       (dor_w),
        .dsr_o       (dsr_w),
        .ctl_reset_o (ctl_reset_w)
    );

    fdc_phase #(.LEN_W(LEN_W), .RES_LEN(RES_LEN)) u_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_reset_i    (ctl_reset_w),
        .data_wr_i      (wr_ok),
        .data_rd_i      (rd_ok),
        .wdata_i        (host_wdata),
        .exec_start_i   (exec_start),
        .exec_dma_i     (exec_dma),
        .exec_to_host_i (exec_to_host),
        .exec_len_i     (exec_len),
        .dma_ack_i      (dma_ack),
        .msr_o          (msr_w),
        .pos_o          (pos_w),
        .dma_req_o      (dma_req),
        .irq_o          (irq),
        .multi_o        (flag_multi),
        .format_o       (flag_format),
        .seek_o         (flag_seek),
        .res_load_o     (res_load_w),
        .cmd_valid_o    (cmd_valid),
        .media_wr_o     (media_wr_strobe),
        .media_take_o   (media_rd_take)
    );

    fdc_result_buf #(.RES_LEN(RES_LEN), .IDX_W(LEN_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (res_load_w),
        .bytes_i (res_bytes),
        .idx_i   (pos_w),
        .byte_o  (res_byte_w)
    );

    always_comb begin
        unique case (host_sel)
            SEL_DOR:  host_rdata = dor_w;
            SEL_STAT: host_rdata = msr_w;
            SEL_DATA: host_rdata = rd_ok ? (msr_w[MSR_NDMA] ? media_rd_data : res_byte_w) : 8'h00;
            default:  host_rdata = dsr_w;
        endcase
    end

    assign media_wr_data = host_wdata;
    assign cmd_byte = host_wdata;
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_sel,
    input logic       host_rd,
    input logic       host_wr,
    input logic       exec_start,
    input logic       dma_ack,
    input logic       dma_req,
    input logic       cmd_valid,
    input logic       media_wr_strobe,
    input logic       irq,
    input logic [7:0] msr
);
    // R2: a refused data read changes no phase state
    p_rd_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == 2'd2 && !(msr[7] && msr[6]) && !exec_start && !dma_ack)
        |=> $stable(msr));

    // R3: a refused data write produces no strobe
    p_wr_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2 && (!msr[7] || msr[6]))
        |-> (!cmd_valid && !media_wr_strobe));

    // R4: the host is locked out while DMA is requested
    p_dma_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (!msr[7] && msr[4]));

    // R5: entering programmed-I/O execution raises the interrupt
    p_pio_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr[5]) |-> irq);

    // R7: a DMA request drops only into the result phase or into reset
    p_end_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> (msr == 8'hD0 || msr == 8'h80));

    // R8: the command phase never shows direction or non-DMA
    p_cmd_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !msr[4] |-> (!msr[6] && !msr[5] && msr[7]));

    // R13: an accepted command byte clears the interrupt
    p_irq_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !exec_start) |=> !irq);
endmodule

bind fdc_host_seq fdc_host_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_sel        (host_sel),
    .host_rd         (host_rd),
    .host_wr         (host_wr),
    .exec_start      (exec_start),
    .dma_ack         (dma_ack),
    .dma_req         (dma_req),
    .cmd_valid       (cmd_valid),
    .media_wr_strobe (media_wr_strobe),
    .irq             (irq),
    .msr             (msr_w)
);

// File: tb/fdc_host_seq_test.sv
module fdc_host_seq_test;
    localparam int LEN_W = 12;
    localparam int RES_LEN = 7;
    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_EX = 3'd2, OP_ACK = 3'd3, OP_CHK = 3'd4;
    localparam int NV = 59;
    // vector: op[24:22] sel[21:20] data[19:12] expect[11:4] req[3:0]
    // CHK expect: bit0 irq, bit1 dma_req, bit2 multi, bit3 format, bit4 seek
    // EX data: bit0 dma, bit1 to_host, bits7..2 length
    localparam logic [24:0] VEC [NV] = '{
        {OP_RD, 2'd1, 8'h00, 8'h80, 4'd1},   // R1 status
        {OP_RD, 2'd0, 8'h00, 8'h04, 4'd1},   // R1 output byte
        {OP_RD, 2'd3, 8'h00, 8'h00, 4'd1},   // R1 rate byte
        {OP_CHK, 2'd0, 8'h00, 8'h00, 4'd1},  // R1 pins
        {OP_RD, 2'd2, 8'h00, 8'h00, 4'd2},   // R2 refused read
        {OP_RD, 2'd1, 8'h00, 8'h80, 4'd2},   // R2 unchanged
        {OP_WR, 2'd2, 8'hCD, 8'h00, 4'd9},   // R9 first byte
        {OP_CHK, 2'd0, 8'h00, 8'h0C, 4'd9},  // R9 multi+format
        {OP_WR, 2'd2, 8'h01, 8'h00, 4'd9},
        {OP_CHK, 2'd0, 8'h00, 8'h0C, 4'd9},  // R9 later byte no effect
        {OP_EX, 2'd0, 8'h08, 8'h00, 4'd5},   // R5 PIO write len 2
        {OP_RD, 2'd1, 8'h00, 8'hB0, 4'd5},
        {OP_CHK, 2'd0, 8'h00, 8'h0D, 4'd5},
        {OP_WR, 2'd2, 8'h11, 8'h00, 4'd13},  // R13
        {OP_CHK, 2'd0, 8'h00, 8'h0C, 4'd13},
        {OP_RD, 2'd1, 8'h00, 8'hB0, 4'd6},   // R6 not yet ended
        {OP_WR, 2'd2, 8'h22, 8'h00, 4'd6},
        {OP_RD, 2'd1, 8'h00, 8'hD0, 4'd6},   // R6 ended
        {OP_CHK, 2'd0, 8'h00, 8'h0D, 4'd7},  // R7 irq
        {OP_WR, 2'd2, 8'h33, 8'h00, 4'd3},   // R3 refused write
        {OP_RD, 2'd1, 8'h00, 8'hD0, 4'd3},
        {OP_RD, 2'd2, 8'h00, 8'hA0, 4'd8},   // R8 result bytes
        {OP_RD, 2'd2, 8'h00, 8'hA1, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA2, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA3, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA4, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA5, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA6, 4'd8},
        {OP_RD, 2'd1, 8'h00, 8'h80, 4'd8},
        {OP_CHK, 2'd0, 8'h00, 8'h0C, 4'd13},
        {OP_WR, 2'd2, 8'h0F, 8'h00, 4'd9},   // R9 seek opcode
        {OP_CHK, 2'd0, 8'h00, 8'h10, 4'd9},
        {OP_EX, 2'd0, 8'h0F, 8'h00, 4'd4},   // R4 DMA len 3
        {OP_RD, 2'd1, 8'h00, 8'h10, 4'd4},
        {OP_CHK, 2'd0, 8'h00, 8'h12, 4'd4},
        {OP_WR, 2'd2, 8'h44, 8'h00, 4'd3},   // R3 refused in DMA
        {OP_RD, 2'd2, 8'h00, 8'h00, 4'd2},   // R2 refused in DMA
        {OP_RD, 2'd1, 8'h00, 8'h10, 4'd2},
        {OP_ACK, 2'd0, 8'h00, 8'h00, 4'd7},  // R7
        {OP_ACK, 2'd0, 8'h00, 8'h00, 4'd7},
        {OP_ACK, 2'd0, 8'h00, 8'h00, 4'd7},
        {OP_CHK, 2'd0, 8'h00, 8'h11, 4'd7},
        {OP_RD, 2'd1, 8'h00, 8'hD0, 4'd7},
        {OP_RD, 2'd2, 8'h00, 8'hA0, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA1, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA2, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA3, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA4, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA5, 4'd8},
        {OP_RD, 2'd2, 8'h00, 8'hA6, 4'd8},
        {OP_RD, 2'd1, 8'h00, 8'h80, 4'd8},
        {OP_WR, 2'd2, 8'h46, 8'h00, 4'd9},
        {OP_CHK, 2'd0, 8'h00, 8'h00, 4'd9},
        {OP_EX, 2'd0, 8'h0A, 8'h00, 4'd5},   // R5 PIO read len 2
        {OP_RD, 2'd1, 8'h00, 8'hF0, 4'd5},
        {OP_RD, 2'd2, 8'h00, 8'h5C, 4'd14},  // R14
        {OP_RD, 2'd1, 8'h00, 8'hF0, 4'd14},
        {OP_RD, 2'd2, 8'h00, 8'h5C, 4'd14},
        {OP_RD, 2'd1, 8'h00, 8'hD0, 4'd14}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic exec_start = 1'b0, exec_dma = 1'b0, exec_to_host = 1'b0;
    logic [LEN_W-1:0] exec_len = '0;
    logic [8*RES_LEN-1:0] res_bytes;
    logic dma_req, dma_ack = 1'b0;
    logic [7:0] media_rd_data = 8'h5C;
    logic media_rd_take, media_wr_strobe, cmd_valid;
    logic [7:0] media_wr_data, cmd_byte;
    logic flag_multi, flag_format, flag_seek, irq;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    for (genvar i = 0; i < RES_LEN; i++) begin : g_res
        assign res_bytes[8*i +: 8] = 8'hA0 + 8'(i);
    end

    fdc_host_seq #(.LEN_W(LEN_W), .RES_LEN(RES_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .exec_start(exec_start),
        .exec_dma(exec_dma), .exec_to_host(exec_to_host), .exec_len(exec_len),
        .res_bytes(res_bytes), .dma_req(dma_req), .dma_ack(dma_ack),
        .media_rd_data(media_rd_data), .media_rd_take(media_rd_take),
        .media_wr_strobe(media_wr_strobe), .media_wr_data(media_wr_data),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .flag_multi(flag_multi),
        .flag_format(flag_format), .flag_seek(flag_seek), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input logic [3:0] rq);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: got %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic run_op(input logic [24:0] v);
        logic [2:0] op;
        op = v[24:22];
        @(negedge clk);
        case (op)
            OP_WR: begin host_sel = v[21:20]; host_wdata = v[19:12]; host_wr = 1'b1; end
            OP_RD: begin host_sel = v[21:20]; host_rd = 1'b1; #1 check(host_rdata, v[11:4], v[3:0]); end
            OP_EX: begin
                exec_start = 1'b1; exec_dma = v[12]; exec_to_host = v[13];
                exec_len = LEN_W'(v[19:14]);
            end
            OP_ACK: dma_ack = 1'b1;
            default: check({3'b000, flag_seek, flag_format, flag_multi, dma_req, irq}, v[11:4], v[3:0]);
        endcase
        if (op != OP_CHK) begin
            @(posedge clk);
            #1;
            host_rd = 1'b0; host_wr = 1'b0; exec_start = 1'b0; dma_ack = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_op(VEC[i]);

        // R10: power-down write resets and stores the value
        run_op({OP_WR, 2'd1, 8'h42, 8'h00, 4'd10});
        run_op({OP_CHK, 2'd0, 8'h00, 8'h01, 4'd10});
        run_op({OP_RD, 2'd3, 8'h00, 8'h42, 4'd10});
        run_op({OP_RD, 2'd1, 8'h00, 8'h80, 4'd10});
        run_op({OP_RD, 2'd3, 8'h00, 8'h02, 4'd11});  // R11 power-down cleared
        // R12: held in reset, data writes ignored; release resets with irq
        run_op({OP_WR, 2'd1, 8'h40, 8'h00, 4'd12});
        run_op({OP_WR, 2'd0, 8'h00, 8'h00, 4'd12});
        run_op({OP_WR, 2'd2, 8'h99, 8'h00, 4'd12});
        run_op({OP_CHK, 2'd0, 8'h00, 8'h01, 4'd12});
        run_op({OP_RD, 2'd0, 8'h00, 8'h00, 4'd12});
        run_op({OP_WR, 2'd0, 8'h04, 8'h00, 4'd12});
        run_op({OP_RD, 2'd3, 8'h00, 8'h00, 4'd12});
        run_op({OP_CHK, 2'd0, 8'h00, 8'h01, 4'd12});
        run_op({OP_RD, 2'd1, 8'h00, 8'h80, 4'd12});
        // R11: status read forces the reset bit inactive
        run_op({OP_WR, 2'd0, 8'h00, 8'h00, 4'd11});
        run_op({OP_RD, 2'd1, 8'h00, 8'h80, 4'd11});
        run_op({OP_RD, 2'd0, 8'h00, 8'h04, 4'd11});
        // R1: hardware reset in the middle of a DMA execution
        run_op({OP_WR, 2'd2, 8'h06, 8'h00, 4'd1});
        run_op({OP_EX, 2'd0, 8'h11, 8'h00, 4'd1});
        run_op({OP_CHK, 2'd0, 8'h00, 8'h02, 4'd1});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_op({OP_RD, 2'd1, 8'h00, 8'h80, 4'd1});
        run_op({OP_CHK, 2'd0, 8'h00, 8'h00, 4'd1});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule